// File: doc/BRIEF.md
# Two-Context Urgency Switch Controller

This block decides when a coarse-grained multithreaded core with two hardware contexts hands the pipeline from the running (foreground) context to the waiting (background) one. Each context carries a 3-bit urgency score. Events reported per thread move the score up or down: a long-latency blocking miss, the return of missed data, an external interrupt, and a fairness timeout.

Whenever the foreground score is strictly below the background score, the controller starts a switch. It raises a one-cycle flush request, holds a busy flag while the pipeline drains for a fixed number of cycles, and then flips the foreground thread ID. While the flush is in progress it makes no new switch decision, but urgency still follows incoming events. The timeout counts only cycles in which the foreground context runs, and each switch restarts it.

The two urgency scores are brought out on a port, so that the surrounding core and the bench can observe them. Saving and restoring register state is left to the core.

Top module: `urgency_switch_ctl`

## Requirements
- R1: After reset, both urgencies are 5, the foreground ID is 0, and the flush request and busy flag are low.
- R2: A miss event on a thread lowers its urgency by one on the next clock edge. At 0 the urgency stays at 0.
- R3: An interrupt event on a thread sets its urgency to 6 on the next edge. It wins over a miss or a data return on the same thread in the same cycle.
- R4: A data-return event sets the thread's urgency to 5 if the urgency is below 6, and leaves 6 or 7 unchanged. A miss in the same cycle wins over the return.
- R5: After 1024 consecutive run cycles of the foreground context, the timeout sets the background thread's urgency to 7. This takes priority over every other event on that thread.
- R6: In a run cycle where the foreground urgency is strictly lower than the background urgency, busy rises on the next edge, and the flush request is high for that first busy cycle only.
- R7: Busy stays high for exactly 5 cycles. The foreground ID toggles on the edge where busy falls, and at no other time.
- R8: During a flush no switch is started, and events still update the urgencies. The comparison resumes in the first run cycle after the flush.
- R9: The timeout counter advances only in run cycles and is cleared when a switch starts.
- R10: The port urgency_o carries thread 0 in bits [2:0] and thread 1 in bits [5:3].

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| miss_i | input | 2 | Blocking miss event, one bit per thread |
| ret_i | input | 2 | Data-return event, one bit per thread |
| irq_i | input | 2 | External interrupt event, one bit per thread |
| flush_o | output | 1 | One-cycle pipeline flush request at the start of a switch |
| fg_id_o | output | 1 | ID of the foreground thread |
| switch_busy_o | output | 1 | High while a switch flush is in progress |
| urgency_o | output | 6 | Urgency of both threads, thread 0 in the low bits |

## Verification
The bench drives the event priorities on the same thread, where interrupt beats miss, miss beats return, and a return leaves 6 or 7 untouched. A design with the order swapped would end with the wrong urgency. It drives a miss at zero, where a wrapping counter would jump to 7 and force a spurious switch. It raises an interrupt in the middle of a flush: a design that re-evaluated during the flush would pulse flush again or stretch busy, and one that froze the comparison would miss the switch back that must follow. It also measures the timeout from the end of a switch, which catches a counter that is not cleared or that keeps counting during the flush, because such a counter fires early.

// File: rtl/usw_pkg.sv
package usw_pkg;
  localparam int URG_W   = 3;
  localparam int NUM_CTX = 2;

  typedef logic [URG_W-1:0] urg_t;

  typedef enum logic {ST_RUN = 1'b0, ST_FLUSH = 1'b1} sw_state_e;

  // Next urgency of one thread from its events, highest priority first:
  // timeout, interrupt, miss (saturating decrement), data return.
  function automatic urg_t urg_next(input urg_t cur, input logic tmo,
                                    input logic irq, input logic miss,
                                    input logic ret, input urg_t tmo_lvl,
                                    input urg_t irq_lvl, input urg_t nom_lvl);
    urg_t r;
    r = cur;
    if (tmo)
      r = tmo_lvl;
    else if (irq)
      r = irq_lvl;
    else if (miss)
      r = (cur == '0) ? '0 : cur - urg_t'(1);
    else if (ret)
      r = (cur < irq_lvl) ? nom_lvl : cur;
    return r;
  endfunction

  // Switch is wanted when the foreground urgency is strictly lower.
  function automatic logic want_switch(input urg_t fg, input urg_t bg);
    return fg < bg;
  endfunction
endpackage

// File: rtl/usw_urg_tracker.sv
module usw_urg_tracker
  import usw_pkg::*;
#(
  parameter urg_t NOM_LVL = 3'd5,
  parameter urg_t IRQ_LVL = 3'd6,
  parameter urg_t TMO_LVL = 3'd7
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tmo_i,
  input  logic irq_i,
  input  logic miss_i,
  input  logic ret_i,
  output urg_t urg_o
);
  urg_t urg_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      urg_q <= NOM_LVL;
    else
      urg_q <= urg_next(urg_q, tmo_i, irq_i, miss_i, ret_i,
                        TMO_LVL, IRQ_LVL, NOM_LVL);
  end

  assign urg_o = urg_q;
endmodule

// File: rtl/usw_timeout.sv
module usw_timeout #(
  parameter int LIMIT = 1024
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  input  logic clr_i,
  output logic expire_o
);
  localparam int CW = (LIMIT > 1) ? $clog2(LIMIT) : 1;
  localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

  logic [CW-1:0] cnt_q;

  assign expire_o = run_i && !clr_i && (cnt_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cnt_q <= '0;
    else if (clr_i || expire_o)
      cnt_q <= '0;
    else if (run_i)
      cnt_q <= cnt_q + CW'(1);
  end
endmodule

// File: rtl/usw_switch_fsm.sv
module usw_switch_fsm
  import usw_pkg::*;
#(
  parameter int FLUSH_CYCLES = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  urg_t urg_fg_i,
  input  urg_t urg_bg_i,
  output logic go_o,
  output logic run_o,
  output logic busy_o,
  output logic flush_o,
  output logic fg_id_o
);
  localparam int FW = (FLUSH_CYCLES > 1) ? $clog2(FLUSH_CYCLES) : 1;
  localparam logic [FW-1:0] FLUSH_LAST = FW'(FLUSH_CYCLES - 1);

  sw_state_e     state_q;
  logic [FW-1:0] cnt_q;
  logic          fg_q;

  assign run_o   = (state_q == ST_RUN);
  assign go_o    = run_o && want_switch(urg_fg_i, urg_bg_i);
  assign busy_o  = (state_q == ST_FLUSH);
  assign flush_o = busy_o && (cnt_q == '0);
  assign fg_id_o = fg_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_RUN;
      cnt_q   <= '0;
      fg_q    <= 1'b0;
    end else begin
      case (state_q)
        ST_RUN: begin
          if (go_o) begin
            state_q <= ST_FLUSH;
            cnt_q   <= '0;
          end
        end
        ST_FLUSH: begin
          if (cnt_q == FLUSH_LAST) begin
            state_q <= ST_RUN;
            cnt_q   <= '0;
            fg_q    <= ~fg_q;
          end else begin
            cnt_q <= cnt_q + FW'(1);
          end
        end
        default: state_q <= ST_RUN;
      endcase
    end
  end
endmodule

// File: rtl/urgency_switch_ctl.sv
module urgency_switch_ctl
  import usw_pkg::*;
#(
  parameter int   TIMEOUT_CYCLES = 1024,
  parameter int   FLUSH_CYCLES   = 5,
  parameter urg_t NOM_LVL        = 3'd5,
  parameter urg_t IRQ_LVL        = 3'd6,
  parameter urg_t TMO_LVL        = 3'd7
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NUM_CTX-1:0]       miss_i,
  input  logic [NUM_CTX-1:0]       ret_i,
  input  logic [NUM_CTX-1:0]       irq_i,
  output logic                     flush_o,
  output logic                     fg_id_o,
  output logic                     switch_busy_o,
  output logic [NUM_CTX*URG_W-1:0] urgency_o
);
  urg_t urg   [NUM_CTX];
  logic [NUM_CTX-1:0] tmo_thr;
  logic tmo_fire;
  logic sw_go;
  logic run;
  logic fg_id;
  urg_t urg_fg;
  urg_t urg_bg;

  assign urg_fg = urg[fg_id];
  assign urg_bg = urg[~fg_id];

  for (genvar t = 0; t < NUM_CTX; t++) begin : g_thr
    localparam logic TID = 1'(t);
    assign tmo_thr[t] = tmo_fire && (fg_id != TID);

    usw_urg_tracker #(
      .NOM_LVL(NOM_LVL), .IRQ_LVL(IRQ_LVL), .TMO_LVL(TMO_LVL)
    ) u_trk (
      .clk(clk), .rst_n(rst_n), .tmo_i(tmo_thr[t]), .irq_i(irq_i[t]),
      .miss_i(miss_i[t]), .ret_i(ret_i[t]), .urg_o(urg[t])
    );

    assign urgency_o[t*URG_W +: URG_W] = urg[t];
  end

  usw_timeout #(.LIMIT(TIMEOUT_CYCLES)) u_tmo (
    .clk(clk), .rst_n(rst_n), .run_i(run), .clr_i(sw_go), .expire_o(tmo_fire)
  );

  usw_switch_fsm #(.FLUSH_CYCLES(FLUSH_CYCLES)) u_fsm (
    .clk(clk), .rst_n(rst_n), .urg_fg_i(urg_fg), .urg_bg_i(urg_bg),
    .go_o(sw_go), .run_o(run), .busy_o(switch_busy_o), .flush_o(flush_o),
    .fg_id_o(fg_id)
  );

  assign fg_id_o = fg_id;
endmodule

// File: rtl/urgency_switch_chk.sv
module urgency_switch_chk
  import usw_pkg::*;
#(
  parameter int FLUSH_CYCLES = 5,
  parameter urg_t IRQ_LVL    = 3'd6
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic [NUM_CTX-1:0]       miss_i,
  input logic [NUM_CTX-1:0]       irq_i,
  input logic [NUM_CTX-1:0]       tmo_thr,
  input logic                     flush_o,
  input logic                     fg_id_o,
  input logic                     switch_busy_o,
  input logic [NUM_CTX*URG_W-1:0] urgency_o
);
  logic [7:0] busy_len;
  urg_t u0, u1, ufg, ubg;

  assign u0  = urgency_o[URG_W-1:0];
  assign u1  = urgency_o[2*URG_W-1:URG_W];
  assign ufg = fg_id_o ? u1 : u0;
  assign ubg = fg_id_o ? u0 : u1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                busy_len <= '0;
    else if (switch_busy_o)    busy_len <= busy_len + 8'd1;
    else                       busy_len <= '0;
  end

  assert_flush_first_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(switch_busy_o) |-> flush_o);

  assert_flush_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    flush_o |=> !flush_o);

  assert_switch_start_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!switch_busy_o && (ufg < ubg)) |=> switch_busy_o);

  assert_fg_change_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(fg_id_o) |-> $fell(switch_busy_o));

  assert_busy_len_R7: assert property (@(posedge clk) disable iff (!rst_n)
    switch_busy_o |-> (busy_len < 8'(FLUSH_CYCLES)));

  assert_sat_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (u1 == '0 && miss_i[1] && !irq_i[1] && !tmo_thr[1]) |=> (u1 == '0));

  assert_irq_level_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_i[0] && !tmo_thr[0]) |=> (u0 == IRQ_LVL));

  assert_tmo_level_R5: assert property (@(posedge clk) disable iff (!rst_n)
    tmo_thr[1] |=> (u1 == 3'd7));
endmodule

bind urgency_switch_ctl urgency_switch_chk #(
  .FLUSH_CYCLES(FLUSH_CYCLES), .IRQ_LVL(IRQ_LVL)
) u_chk (
  .clk(clk), .rst_n(rst_n), .miss_i(miss_i), .irq_i(irq_i),
  .tmo_thr(tmo_thr), .flush_o(flush_o), .fg_id_o(fg_id_o),
  .switch_busy_o(switch_busy_o), .urgency_o(urgency_o)
);

// File: tb/urgency_switch_ctl_test.sv
`timescale 1ns/1ps
module urgency_switch_ctl_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] miss_i = '0, ret_i = '0, irq_i = '0;
  logic       flush_o, fg_id_o, switch_busy_o;
  logic [5:0] urgency_o;
  int total = 0;
  int bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  urgency_switch_ctl uut (
    .clk(clk), .rst_n(rst_n), .miss_i(miss_i), .ret_i(ret_i), .irq_i(irq_i),
    .flush_o(flush_o), .fg_id_o(fg_id_o), .switch_busy_o(switch_busy_o),
    .urgency_o(urgency_o)
  );

  // {miss[1:0], ret[1:0], irq[1:0], expected u0, expected u1}
  localparam int NV = 12;
  localparam logic [11:0] VEC [NV] = '{
    {2'b10, 2'b00, 2'b00, 3'd5, 3'd4},  // R2 miss t1
    {2'b10, 2'b00, 2'b00, 3'd5, 3'd3},  // R2
    {2'b00, 2'b00, 2'b01, 3'd6, 3'd3},  // R3 irq t0
    {2'b00, 2'b10, 2'b00, 3'd6, 3'd5},  // R4 return restores 5
    {2'b01, 2'b00, 2'b00, 3'd5, 3'd5},  // R2 miss t0
    {2'b01, 2'b00, 2'b01, 3'd6, 3'd5},  // R3 irq beats miss
    {2'b00, 2'b01, 2'b00, 3'd6, 3'd5},  // R4 return leaves 6
    {2'b10, 2'b00, 2'b00, 3'd6, 3'd4},  // R2
    {2'b10, 2'b10, 2'b00, 3'd6, 3'd3},  // R4 miss beats return
    {2'b00, 2'b00, 2'b00, 3'd6, 3'd3},  // R10 idle holds
    {2'b00, 2'b10, 2'b00, 3'd6, 3'd5},  // R4
    {2'b01, 2'b00, 2'b00, 3'd5, 3'd5}   // R2
  };

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic do_reset();
    rst_n = 1'b0; miss_i = '0; ret_i = '0; irq_i = '0;
    repeat (2) @(posedge clk);
    #1 rst_n = 1'b1;
  endtask

  function automatic int u0(); return int'(urgency_o[2:0]); endfunction
  function automatic int u1(); return int'(urgency_o[5:3]); endfunction

  initial begin
    #(200000 * 4);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    // R1 reset state
    do_reset();
    check("R1 u0", u0(), 5);
    check("R1 u1", u1(), 5);
    check("R1 fg", fg_id_o, 0);
    check("R1 busy", switch_busy_o, 0);
    check("R1 flush", flush_o, 0);

    // Table walk: event priorities, no switch expected
    for (int i = 0; i < NV; i++) begin
      {miss_i, ret_i, irq_i} = VEC[i][11:6];
      step();
      check($sformatf("R10 vec%0d u0", i), u0(), int'(VEC[i][5:3]));
      check($sformatf("R10 vec%0d u1", i), u1(), int'(VEC[i][2:0]));
      check($sformatf("R6 vec%0d busy", i), switch_busy_o, 0);
    end
    miss_i = '0; ret_i = '0; irq_i = '0;

    // R2 saturation at zero on background thread
    do_reset();
    miss_i = 2'b10;
    repeat (7) step();
    miss_i = '0;
    check("R2 saturate", u1(), 0);
    check("R2 no switch", switch_busy_o, 0);

    // R6 R7 R9 switch, then timeout measured from end of flush
    do_reset();
    miss_i = 2'b01;
    step();
    miss_i = '0;
    check("R6 before switch busy", switch_busy_o, 0);
    step();
    check("R6 busy rises", switch_busy_o, 1);
    check("R6 flush pulse", flush_o, 1);
    for (int k = 0; k < 4; k++) begin
      step();
      check("R7 busy held", switch_busy_o, 1);
      check("R6 flush single", flush_o, 0);
      check("R7 fg held", fg_id_o, 0);
    end
    step();
    check("R7 busy falls", switch_busy_o, 0);
    check("R7 fg toggles", fg_id_o, 1);
    repeat (1023) step();
    check("R9 no early timeout", u0(), 4);
    step();
    check("R9 timeout after clear", u0(), 7);
    check("R5 no switch yet", switch_busy_o, 0);
    step();
    check("R5 timeout causes switch", switch_busy_o, 1);

    // R8 event during flush, decision resumes after
    do_reset();
    miss_i = 2'b01;
    step();
    miss_i = '0;
    step();
    check("R8 flush start", flush_o, 1);
    irq_i = 2'b01;
    step();
    irq_i = '0;
    check("R8 urgency updates in flush", u0(), 6);
    check("R8 no new flush", flush_o, 0);
    repeat (3) step();
    check("R8 busy still", switch_busy_o, 1);
    check("R8 flush still single", flush_o, 0);
    step();
    check("R8 flush ends", switch_busy_o, 0);
    check("R8 fg now 1", fg_id_o, 1);
    step();
    check("R8 re-evaluated switch", switch_busy_o, 1);
    check("R8 re-evaluated flush", flush_o, 1);

    // R5 timeout from reset, return cannot lower 7 (R4)
    do_reset();
    repeat (1023) step();
    check("R5 before timeout", u1(), 5);
    check("R5 fg unchanged", u0(), 5);
    step();
    check("R5 timeout sets bg to 7", u1(), 7);
    ret_i = 2'b10;
    step();
    ret_i = '0;
    check("R4 return keeps 7", u1(), 7);
    check("R5 switch starts", switch_busy_o, 1);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule